// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Controller

This synchronous block sits between a controller and the two gate drivers of one half-bridge leg. It receives a low-side command that is asserted low and a high-side command that is asserted high, and produces two registered gate-enable outputs, `lo_gate` and `hi_gate`. It keeps the two switches from conducting together in two ways. A request for both sides at once is refused and both outputs go off. Each turn-on also waits for a minimum off gap, and that gap is timed from the moment an output actually went off, not from the command edge.

Two digitized supply readings, in unsigned 8-bit codes of 0.1 V per step, feed two hysteresis flags. The main-supply flag gates both outputs. The floating-supply flag gates only the high side. If both command pins are tied to one signal, the leg is driven complementarily and the off gap is inserted at every change of level.

The control core is a four-state machine. `ST_GAP` holds both outputs off while a counter runs. `ST_READY` holds both off once the gap has expired. `ST_LO` and `ST_HI` each enable one output. These are the transitions:
- Reset, a main flag that reads low, or a dropped request in `ST_LO`/`ST_HI` leads to `ST_GAP` with the counter cleared.
- `ST_GAP` leads to `ST_LO`, `ST_HI` or `ST_READY` on the last gap cycle.
- `ST_READY` leads to `ST_LO`/`ST_HI` on a request.
- A rising floating flag while both outputs are off sends `ST_GAP`/`ST_READY` back to `ST_GAP` and restarts the counter.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: The command pair decodes as follows (low-side pin, high-side pin to outputs). (0,0) gives `lo_gate` only. (1,1) gives `hi_gate` only. (1,0) and (0,1) give both outputs off. A change on the pins reaches the outputs on the third rising clock edge after it.
- R2: `lo_gate` and `hi_gate` are never 1 in the same cycle.
- R3: After an output goes off, both outputs stay off for at least `DT_CYCLES` clock cycles before either output turns on.
- R4: When a new request arrives before the gap has run out, whether it overlaps the old one or comes in a short while after it, the new output turns on exactly `DT_CYCLES` cycles after the old one went off.
- R5: When a request arrives after the gap has already run out, the output follows it with only the R1 latency.
- R6: With both pins tied to one signal, a 1 enables `hi_gate` and a 0 enables `lo_gate`, with the full gap at every change.
- R7: The main flag sets when the code is at or above 95 and clears when it is at or below 80. Between those codes it holds its value. While it is low both outputs are off. The outputs react on the second rising edge after the code changes.
- R8: The floating flag sets at code 90 or above and clears at code 80 or below. While it is low only `hi_gate` is blocked, and `lo_gate` still follows its command.
- R9: After either flag returns high while both outputs are off, a full `DT_CYCLES` gap passes before any output turns on.
- R10: During and just after reset both outputs are 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_cmd_n | input | 1 | Low-side command, asserted low |
| hi_cmd | input | 1 | High-side command, asserted high |
| vmain_code | input | 8 | Main supply reading, 0.1 V per step |
| vfloat_code | input | 8 | Floating supply reading, 0.1 V per step |
| lo_gate | output | 1 | Low-side gate enable |
| hi_gate | output | 1 | High-side gate enable |

## Verification
The bench goes after the following cases:
- Commands that swap sides with an overlap. A design that times the gap from the command edge would enable the new side too early.
- Swaps that are late but still inside the gap, and swaps that come well after it. A design that adds the gap unconditionally would lag by `DT_CYCLES` where no delay is due.
- Supply codes swept through the hysteresis band. Off-by-one thresholds or a flag without memory show up as wrong enables at codes 80, 90, 94 and 95.
- A floating-flag recovery. A design that skips the restart of the gap there would turn the high side on at once.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_READY = 2'd1,
        ST_LO    = 2'd2,
        ST_HI    = 2'd3
    } leg_state_e;
endpackage

// File: rtl/hb_sync2.sv
module hb_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/hb_supply_flag.sv
module hb_supply_flag #(
    parameter int CODE_W   = 8,
    parameter int ON_CODE  = 95,
    parameter int OFF_CODE = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              good
);
    localparam logic [CODE_W-1:0] ON_C  = CODE_W'(ON_CODE);
    localparam logic [CODE_W-1:0] OFF_C = CODE_W'(OFF_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good <= 1'b0;
        end else if (code >= ON_C) begin
            good <= 1'b1;
        end else if (code <= OFF_C) begin
            good <= 1'b0;
        end
    end

    // R7 / R8 hysteresis thresholds and hold band
    a_r7_hyst_set: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= ON_C) |=> good);
    a_r7_hyst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (code <= OFF_C) |=> !good);
    a_r7_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((code > OFF_C) && (code < ON_C)) |=> (good == $past(good)));
endmodule

// File: rtl/hb_leg_fsm.sv
module hb_leg_fsm
    import hb_pkg::*;
#(
    parameter int DT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_lo,
    input  logic want_hi,
    input  logic main_ok,
    input  logic float_ok,
    output logic lo_gate,
    output logic hi_gate
);
    localparam int CW = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(DT_CYCLES - 1);
    localparam int RW = $clog2(DT_CYCLES + 1) + 1;
    localparam logic [RW-1:0] RUN_MAX = RW'(DT_CYCLES);

    leg_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic fok_q;
    logic req_lo, req_hi, float_rise;

    assign req_lo     = want_lo & main_ok;
    assign req_hi     = want_hi & main_ok & float_ok;
    assign float_rise = float_ok & ~fok_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
            cnt_q   <= '0;
            fok_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            fok_q   <= float_ok;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!main_ok) begin
            state_d = ST_GAP;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_GAP: begin
                    if (float_rise) begin
                        cnt_d = '0;
                    end else if (cnt_q == GAP_LAST) begin
                        if (req_lo)      state_d = ST_LO;
                        else if (req_hi) state_d = ST_HI;
                        else             state_d = ST_READY;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_READY: begin
                    if (float_rise) begin
                        state_d = ST_GAP;
                        cnt_d   = '0;
                    end else if (req_lo) begin
                        state_d = ST_LO;
                    end else if (req_hi) begin
                        state_d = ST_HI;
                    end
                end
                ST_LO: begin
                    if (!req_lo) begin
                        state_d = ST_GAP;
                        cnt_d   = '0;
                    end
                end
                ST_HI: begin
                    if (!req_hi) begin
                        state_d = ST_GAP;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_GAP;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_gate <= 1'b0;
            hi_gate <= 1'b0;
        end else begin
            lo_gate <= (state_d == ST_LO);
            hi_gate <= (state_d == ST_HI);
        end
    end

    // checker: run length of both-off cycles, saturating
    logic [RW-1:0] off_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (lo_gate || hi_gate) begin
            off_run_q <= '0;
        end else if (off_run_q != RUN_MAX) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    // R3: any turn-on is preceded by a full gap
    a_r3_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_gate) || $rose(hi_gate)) |-> (off_run_q >= RUN_MAX));
    // R9: a rising floating flag with the leg off keeps both outputs off next cycle
    a_r9_float_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (float_rise && !lo_gate && !hi_gate) |=> (!lo_gate && !hi_gate));
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
    parameter int DT_CYCLES = 32,
    parameter int CODE_W    = 8,
    parameter int MAIN_ON   = 95,
    parameter int MAIN_OFF  = 80,
    parameter int FLT_ON    = 90,
    parameter int FLT_OFF   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_cmd_n,
    input  logic              hi_cmd,
    input  logic [CODE_W-1:0] vmain_code,
    input  logic [CODE_W-1:0] vfloat_code,
    output logic              lo_gate,
    output logic              hi_gate
);
    logic [1:0] cmd_s;
    logic want_lo, want_hi, main_ok, float_ok;

    hb_sync2 #(.WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({lo_cmd_n, hi_cmd}),
        .dout (cmd_s)
    );

    // R1 decode: bit1 = low-side pin (asserted low), bit0 = high-side pin
    assign want_lo = ~cmd_s[1] & ~cmd_s[0];
    assign want_hi =  cmd_s[1] &  cmd_s[0];

    hb_supply_flag #(.CODE_W(CODE_W), .ON_CODE(MAIN_ON), .OFF_CODE(MAIN_OFF)) u_main_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .code (vmain_code),
        .good (main_ok)
    );

    hb_supply_flag #(.CODE_W(CODE_W), .ON_CODE(FLT_ON), .OFF_CODE(FLT_OFF)) u_float_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .code (vfloat_code),
        .good (float_ok)
    );

    hb_leg_fsm #(.DT_CYCLES(DT_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_lo (want_lo),
        .want_hi (want_hi),
        .main_ok (main_ok),
        .float_ok(float_ok),
        .lo_gate (lo_gate),
        .hi_gate (hi_gate)
    );

    // R2: never both enabled
    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_gate && hi_gate));
    // R7: main flag low blocks both
    a_r7_main_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !main_ok |=> (!lo_gate && !hi_gate));
    // R8: floating flag low blocks the high side
    a_r8_float_blocks_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !float_ok |=> !hi_gate);
endmodule

// File: tb/hb_deadtime_ctrl_bench.sv
module hb_deadtime_ctrl_bench;
    localparam int DT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic hi_cmd = 1'b0;
    logic [7:0] vmain_code = 8'd0;
    logic [7:0] vfloat_code = 8'd0;
    logic lo_gate, hi_gate;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R10 reset";

    always #2 clk = ~clk;

    hb_deadtime_ctrl u_hb_deadtime_ctrl (
        .clk(clk), .rst_n(rst_n), .lo_cmd_n(lo_cmd_n), .hi_cmd(hi_cmd),
        .vmain_code(vmain_code), .vfloat_code(vfloat_code),
        .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    // expected-value model built from the requirements
    logic [1:0] m_p1, m_p2;
    logic m_mok, m_fok, m_fokd, m_lo, m_hi;
    int   m_g;

    function automatic logic hyst(input logic cur, input int code, input int on_c, input int off_c);
        if (code >= on_c) return 1'b1;
        if (code <= off_c) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= 2'b00; m_p2 <= 2'b00;
            m_mok <= 0; m_fok <= 0; m_fokd <= 0;
            m_lo <= 0; m_hi <= 0; m_g <= 0;
        end else begin
            logic rlo, rhi, fr;
            rlo = !m_p2[1] && !m_p2[0] && m_mok;
            rhi = m_p2[1] && m_p2[0] && m_mok && m_fok;
            fr  = m_fok && !m_fokd;
            m_p1 <= {lo_cmd_n, hi_cmd};
            m_p2 <= m_p1;
            m_mok <= hyst(m_mok, vmain_code, 95, 80);
            m_fok <= hyst(m_fok, vfloat_code, 90, 80);
            m_fokd <= m_fok;
            if (!m_mok) begin
                m_lo <= 0; m_hi <= 0; m_g <= 0;
            end else if (m_lo) begin
                if (!rlo) begin m_lo <= 0; m_g <= 0; end
            end else if (m_hi) begin
                if (!rhi) begin m_hi <= 0; m_g <= 0; end
            end else if (fr) begin
                m_g <= 0;
            end else if (m_g >= DT - 1) begin
                if (rlo) m_lo <= 1;
                else if (rhi) m_hi <= 1;
            end else begin
                m_g <= m_g + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual {lo,hi}=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    int   off_run = 0;
    logic prev_on = 0;

    task automatic step();
        @(negedge clk);
        chk(phase, {lo_gate, hi_gate}, {m_lo, m_hi});
        if (lo_gate && hi_gate) chk("R2 both on", 2'b11, 2'b00);
        if ((lo_gate || hi_gate) && !prev_on) begin
            total++;
            if (off_run < DT) begin
                bad++;
                $display("FAIL R3 gap: actual %0d expected >= %0d", off_run, DT);
            end
        end
        prev_on = lo_gate || hi_gate;
        off_run = prev_on ? 0 : off_run + 1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drive(input logic ln, input logic h);
        lo_cmd_n = ln; hi_cmd = h;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {lo_gate, hi_gate}, 2'b00);
        rst_n = 1'b1;
        run(5);
        chk("R10 after reset, supply low", {lo_gate, hi_gate}, 2'b00);

        phase = "R1 decode";
        vmain_code = 8'd120; vfloat_code = 8'd120;
        run(DT + 10);
        chk("R1 both pins low gives low side", {lo_gate, hi_gate}, 2'b10);
        drive(1'b1, 1'b0); run(DT + 5);
        chk("R1 (1,0) both off", {lo_gate, hi_gate}, 2'b00);
        drive(1'b1, 1'b1); run(2);
        chk("R5 latency not yet", {lo_gate, hi_gate}, 2'b00);
        run(1);
        chk("R5 third edge high side", {lo_gate, hi_gate}, 2'b01);
        run(20);
        drive(1'b0, 1'b1); run(DT + 5);
        chk("R1 (0,1) both off", {lo_gate, hi_gate}, 2'b00);

        phase = "R4 overlap";
        drive(1'b0, 1'b0); run(DT + 5);
        drive(1'b0, 1'b1); run(4);
        drive(1'b1, 1'b1); run(DT + 6);
        chk("R4 overlap ends on high side", {lo_gate, hi_gate}, 2'b01);
        phase = "R4 short gap";
        drive(1'b1, 1'b0); run(5);
        drive(1'b0, 1'b0); run(DT + 4);
        phase = "R5 long gap";
        drive(1'b1, 1'b0); run(DT + 20);
        drive(1'b1, 1'b1); run(10);

        phase = "R6 tied";
        for (int k = 0; k < 12; k++) begin
            logic v;
            v = k[0];
            drive(v, v);
            run(5 + (k * 7) % 50);
        end
        drive(1'b0, 1'b0); run(DT + 5);
        chk("R6 tied low drives low side", {lo_gate, hi_gate}, 2'b10);

        phase = "R7 main hysteresis";
        vmain_code = 8'd90; run(10);
        chk("R7 in-band holds good", {lo_gate, hi_gate}, 2'b10);
        vmain_code = 8'd81; run(5);
        vmain_code = 8'd80; run(2);
        chk("R7 code 80 blocks", {lo_gate, hi_gate}, 2'b00);
        vmain_code = 8'd94; run(DT + 10);
        chk("R7 code 94 stays blocked", {lo_gate, hi_gate}, 2'b00);
        vmain_code = 8'd95; run(DT + 3);
        chk("R9 gap after main return", {lo_gate, hi_gate}, 2'b10);

        phase = "R8 float hysteresis";
        vfloat_code = 8'd80; run(10);
        chk("R8 low side unaffected", {lo_gate, hi_gate}, 2'b10);
        drive(1'b1, 1'b1); run(DT + 10);
        chk("R8 high side blocked", {lo_gate, hi_gate}, 2'b00);
        vfloat_code = 8'd89; run(10);
        phase = "R9 float return";
        vfloat_code = 8'd90; run(3);
        chk("R9 no instant enable", {lo_gate, hi_gate}, 2'b00);
        run(DT + 5);
        chk("R8 code 90 releases", {lo_gate, hi_gate}, 2'b01);

        phase = "random R1 R3 R4 R5 R7 R8 R9";
        for (int b = 0; b < 400; b++) begin
            drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 9) == 0)
                vmain_code = ($urandom_range(0, 1) != 0) ? 8'd120 : 8'($urandom_range(75, 100));
            if ($urandom_range(0, 7) == 0)
                vfloat_code = ($urandom_range(0, 1) != 0) ? 8'd120 : 8'($urandom_range(75, 95));
            run($urandom_range(1, 80));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule